// File: doc/BRIEF.md
# Mixed-Criticality Hardware Thread Scheduler

This block decides, in every clock cycle, which hardware thread of a fine-grained multithreaded pipeline may issue its next instruction. Each thread is either hard real-time or soft real-time. Hard real-time threads own entries in a small slot table, which a pointer walks one entry per cycle. Because of this, each such thread issues at a fixed, configured rate that no other thread can disturb. Soft real-time threads share every other cycle in round-robin order. They also take any reserved cycle whose owner is inactive or stalled, so that cycle is not wasted.

The slot table, the class of each thread, the table length and a comparison mode are written through a simple register-write port. The comparison mode is plain round-robin over all threads that can issue. Writes go into shadow copies. They become live only when the table pointer wraps, so a rotation already in progress is never altered. The thread status inputs are per-thread "active" and "ready" flags. The result is a valid flag and a thread number, and both follow the current slot and the present status inputs within the same cycle.

Top module: `mc_thread_sched`

## Requirements
- R1: At most one thread is granted per cycle. When no thread is eligible, `issue_valid` is 0 and `issue_tid` is 0.
- R2: Configuration writes (`cfg_we`=1) decode `cfg_addr` as follows. Addresses 0 to SLOTS-1 are slot entries, where bit 3 set means "free" and bits 2:0 give the owning thread. Address SLOTS is the class mask, where bit i set makes thread i hard real-time. Address SLOTS+1 is the control word, where bits 2:0 hold the index of the last slot used and bit 7 selects round-robin mode.
- R3: In slot mode, when the current entry names a hard real-time thread below NTHREADS that is active and ready, that thread is granted.
- R4: In slot mode, a hard real-time thread is never granted in a slot that it does not own.
- R5: When the owner of the current reserved slot is inactive or not ready, the cycle goes to an eligible soft real-time thread.
- R6: Soft real-time grants follow round-robin order, starting from the thread after the last soft real-time grant. Hard real-time grants do not move this order.
- R7: The slot pointer advances by one entry each cycle and returns to entry 0 after the programmed last index, so the table length is 1 to SLOTS.
- R8: A configuration write made in any cycle of a rotation, including its last cycle, takes effect from the first slot of the next rotation and not earlier.
- R9: In round-robin mode, all threads that are active and ready are granted in round-robin order, regardless of the table and the classes.
- R10: A slot entry that names a soft real-time thread, or a thread number at or above NTHREADS, behaves as a free entry.
- R11: After reset, all entries are free, no thread is hard real-time, the table length is SLOTS, slot mode is selected, the pointer is at entry 0, and thread 0 is the first round-robin choice.
- R12: A thread is granted only while its `thr_active` and `thr_ready` bits are both 1.

Verification is described in the last section, after the port table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(SLOTS+2) | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| thr_active | input | NTHREADS | Thread is running |
| thr_ready | input | NTHREADS | Thread can issue this cycle |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | 3 | Granted thread number |

## Verification
The grant is combinational from the registered slot pointer, the live configuration and the present status inputs. Its result is therefore due in the same cycle the inputs are applied. The bench drives inputs 1 ns after a rising edge and samples 4 ns later, before the next edge. Pointer moves and round-robin updates take effect on the following edge, so each expected value is worked out from the count of edges since reset or since the last commit. A configuration write applied after edge k is captured at edge k+1. The bench therefore checks that the slot still behaves under the old settings until the edge that wraps the pointer, and under the new settings right after it.

// File: rtl/sched_pkg.sv
// Shared types and constants for the mixed-criticality thread scheduler.
// Assumes at most eight hardware threads, so a thread number fits in 3 bits.
package sched_pkg;
    localparam int TIDW        = 3;
    localparam int MAX_THREADS = 8;
    localparam int WDW         = 8;   // configuration write-data width
    localparam int MODE_BIT    = 7;   // control word: round-robin mode select

    // One slot-table entry: free flag plus owner thread number
    typedef struct packed {
        logic            free;
        logic [TIDW-1:0] tid;
    } slot_ent_t;

    localparam slot_ent_t FREE_ENT = '{free: 1'b1, tid: '0};
endpackage

// File: rtl/sched_cfg_regs.sv
// Configuration store: shadow registers take writes at any time, and live
// registers copy them (including a write in the same cycle) on commit.
// Assumes commit is pulsed on the last cycle of a table rotation.
module sched_cfg_regs
    import sched_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int SLOTS    = 8,
    localparam int PW      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int AW      = $clog2(SLOTS + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [WDW-1:0]          wdata,
    input  logic                    commit,
    output slot_ent_t [SLOTS-1:0]   live_ent,
    output logic [NTHREADS-1:0]     live_hrt,
    output logic [PW-1:0]           live_last,
    output logic                    live_rr
);
    localparam logic [AW-1:0] ADDR_HRT = AW'(SLOTS);
    localparam logic [AW-1:0] ADDR_CTL = AW'(SLOTS + 1);
    localparam logic [PW-1:0] LAST_MAX = PW'(SLOTS - 1);

    slot_ent_t [SLOTS-1:0] sh_ent,  sh_ent_nxt;
    logic [NTHREADS-1:0]   sh_hrt,  sh_hrt_nxt;
    logic [PW-1:0]         sh_last, sh_last_nxt;
    logic                  sh_rr,   sh_rr_nxt;
    logic [PW-1:0]         wr_last;
    logic                  unused_wbits;

    assign unused_wbits = ^wdata;

    // Clamp a programmed last index to the table size
    assign wr_last = (wdata[PW-1:0] > LAST_MAX) ? LAST_MAX : wdata[PW-1:0];

    // Next shadow contents: current shadow with this cycle's write merged in
    always_comb begin
        sh_ent_nxt  = sh_ent;
        sh_hrt_nxt  = sh_hrt;
        sh_last_nxt = sh_last;
        sh_rr_nxt   = sh_rr;
        if (we) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (addr == AW'(i)) begin
                    sh_ent_nxt[i] = slot_ent_t'(wdata[TIDW:0]);
                end
            end
            if (addr == ADDR_HRT) sh_hrt_nxt = wdata[NTHREADS-1:0];
            if (addr == ADDR_CTL) begin
                sh_last_nxt = wr_last;
                sh_rr_nxt   = wdata[MODE_BIT];
            end
        end
    end

    // Shadow registers capture every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ent  <= {SLOTS{FREE_ENT}};
            sh_hrt  <= '0;
            sh_last <= LAST_MAX;
            sh_rr   <= 1'b0;
        end else begin
            sh_ent  <= sh_ent_nxt;
            sh_hrt  <= sh_hrt_nxt;
            sh_last <= sh_last_nxt;
            sh_rr   <= sh_rr_nxt;
        end
    end

    // Live registers change only at a rotation boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_ent  <= {SLOTS{FREE_ENT}};
            live_hrt  <= '0;
            live_last <= LAST_MAX;
            live_rr   <= 1'b0;
        end else if (commit) begin
            live_ent  <= sh_ent_nxt;
            live_hrt  <= sh_hrt_nxt;
            live_last <= sh_last_nxt;
            live_rr   <= sh_rr_nxt;
        end
    end

    // R8
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(live_last) && $stable(live_hrt) && $stable(live_rr)));
endmodule

// File: rtl/sched_slot_ptr.sv
// Slot-table pointer: steps one entry per cycle and returns to 0 after the
// programmed last index. Flags the final slot of each rotation.
// Assumes last is only changed on the cycle that wrap is high.
module sched_slot_ptr #(
    parameter int SLOTS = 8,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] last,
    output logic [PW-1:0] ptr,
    output logic          wrap
);
    // Last slot of the rotation
    assign wrap = (ptr == last);

    // Advance or wrap the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (wrap) ptr <= '0;
        else           ptr <= ptr + PW'(1);
    end

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ptr == '0 || ptr == $past(ptr) + PW'(1)));
    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> ptr == '0);
endmodule

// File: rtl/sched_rr_pick.sv
// Round-robin picker: grants the first requester found after the last
// granted thread, wrapping at N. Purely combinational.
// Assumes last is below N.
module sched_rr_pick
    import sched_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]    req,
    input  logic [TIDW-1:0] last,
    output logic            gnt_valid,
    output logic [TIDW-1:0] gnt_id
);
    // Search offsets 1..N from the last grant; the first hit wins
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = TIDW'(idx);
            end
        end
    end
endmodule

// File: rtl/mc_thread_sched.sv
// Mixed-criticality thread scheduler top. Chooses one issuing thread per
// cycle: the hard real-time owner of the current slot when it can issue,
// otherwise a soft real-time thread by round robin. A mode bit selects plain
// round robin over all threads. Assumes 1 <= NTHREADS <= 8.
module mc_thread_sched
    import sched_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int SLOTS    = 8,
    localparam int PW      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int AW      = $clog2(SLOTS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [WDW-1:0]       cfg_wdata,
    input  logic [NTHREADS-1:0]  thr_active,
    input  logic [NTHREADS-1:0]  thr_ready,
    output logic                 issue_valid,
    output logic [TIDW-1:0]      issue_tid
);
    slot_ent_t [SLOTS-1:0] live_ent;
    logic [NTHREADS-1:0]   live_hrt;
    logic [PW-1:0]         live_last;
    logic                  live_rr;
    logic [PW-1:0]         ptr;
    logic                  wrap;
    slot_ent_t             cur;
    logic [NTHREADS-1:0]   elig;
    logic [NTHREADS-1:0]   srt_req;
    logic                  own_hrt, own_elig, reserved_hit;
    logic                  pick_valid, srt_grant;
    logic [TIDW-1:0]       pick_id;
    logic [TIDW-1:0]       rr_last;

    sched_cfg_regs #(.NTHREADS(NTHREADS), .SLOTS(SLOTS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .commit(wrap), .live_ent(live_ent),
        .live_hrt(live_hrt), .live_last(live_last), .live_rr(live_rr)
    );

    sched_slot_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .last(live_last), .ptr(ptr), .wrap(wrap)
    );

    sched_rr_pick #(.N(NTHREADS)) u_pick (
        .req(srt_req), .last(rr_last), .gnt_valid(pick_valid), .gnt_id(pick_id)
    );

    assign cur  = live_ent[ptr];
    assign elig = thr_active & thr_ready;

    // Class and eligibility of the thread named by the current entry
    always_comb begin
        own_hrt  = 1'b0;
        own_elig = 1'b0;
        for (int i = 0; i < NTHREADS; i++) begin
            if (cur.tid == TIDW'(i)) begin
                own_hrt  = live_hrt[i];
                own_elig = elig[i];
            end
        end
    end

    // Reserved slot honoured only for an eligible hard real-time owner
    assign reserved_hit = !live_rr && !cur.free && own_hrt && own_elig;

    // Round-robin pool: every eligible thread in comparison mode, else SRT only
    assign srt_req = live_rr ? elig : (elig & ~live_hrt);

    // Final grant selection
    always_comb begin
        issue_valid = 1'b0;
        issue_tid   = '0;
        srt_grant   = 1'b0;
        if (reserved_hit) begin
            issue_valid = 1'b1;
            issue_tid   = cur.tid;
        end else if (pick_valid) begin
            issue_valid = 1'b1;
            issue_tid   = pick_id;
            srt_grant   = 1'b1;
        end
    end

    // Round-robin position moves only on a pool grant
    always_ff @(posedge clk) begin
        if (!rst_n)         rr_last <= TIDW'(NTHREADS - 1);
        else if (srt_grant) rr_last <= issue_tid;
    end

    // R12
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (((thr_active & thr_ready) >> issue_tid) & NTHREADS'(1)) != '0);
    // R1
    idle_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> issue_tid == '0);
    // R4
    hrt_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !live_rr && ((live_hrt >> issue_tid) & NTHREADS'(1)) != '0)
            |-> (!cur.free && cur.tid == issue_tid));
    // R6
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srt_grant |=> $stable(rr_last));
endmodule

// File: tb/sim_mc_thread_sched.sv
module sim_mc_thread_sched;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [3:0] thr_active, thr_ready;
    logic       issue_valid;
    logic [2:0] issue_tid;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mc_thread_sched #(.NTHREADS(4), .SLOTS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .thr_active(thr_active), .thr_ready(thr_ready),
        .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    typedef struct packed {
        logic [3:0] act;
        logic [3:0] rdy;
        logic       v;
        logic [2:0] tid;
    } vec_t;

    // Live table: slot0=T0(HRT), slot1 free, slot2=T1(HRT), slot3 free; T2,T3 SRT
    localparam vec_t VEC [12] = '{
        '{4'hF, 4'hF, 1'b1, 3'd0},  // slot0 owner T0 (R3)
        '{4'hF, 4'hF, 1'b1, 3'd2},  // free slot, SRT after T1 (R6)
        '{4'hF, 4'hF, 1'b1, 3'd1},  // slot2 owner T1 (R3)
        '{4'hF, 4'hF, 1'b1, 3'd3},  // free slot, SRT next (R6)
        '{4'hF, 4'hE, 1'b1, 3'd2},  // T0 stalled, slot reused (R5)
        '{4'hF, 4'h3, 1'b0, 3'd0},  // only HRT ready in free slot (R4)
        '{4'hD, 4'hF, 1'b1, 3'd3},  // T1 inactive, slot reused (R5)
        '{4'hF, 4'h4, 1'b1, 3'd2},  // single SRT ready (R6)
        '{4'hF, 4'hF, 1'b1, 3'd0},  // fixed rate despite SRT demand (R3)
        '{4'hF, 4'h0, 1'b0, 3'd0},  // nobody ready (R1)
        '{4'h0, 4'hF, 1'b0, 3'd0},  // nobody active (R12)
        '{4'hF, 4'hF, 1'b1, 3'd3}   // round robin continues (R6)
    };

    task automatic check(input string tag, input logic ev, input logic [2:0] et);
        total++;
        if (issue_valid !== ev || issue_tid !== et) begin
            bad++;
            $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                     tag, issue_valid, issue_tid, ev, et);
        end
    endtask

    // One cycle: drive after the edge, sample before the next edge
    task automatic cyc(input logic [3:0] a, input logic [3:0] r, input logic w,
                       input logic [3:0] ad, input logic [7:0] d,
                       input logic ev, input logic [2:0] et, input string tag);
        @(posedge clk);
        #1;
        thr_active = a; thr_ready = r;
        cfg_we = w; cfg_addr = ad; cfg_wdata = d;
        #4;
        check(tag, ev, et);
    endtask

    task automatic wr(input logic [3:0] ad, input logic [7:0] d);
        @(posedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        thr_active = '0; thr_ready = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #4 check("R11 reset idle", 1'b0, 3'd0);
        // R2: program table, classes and length 4 (writes captured at edges 2..7)
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h08);
        wr(4'd2, 8'h01);
        wr(4'd3, 8'h08);
        wr(4'd8, 8'h03);
        wr(4'd9, 8'h03);
        // Last cycle of first rotation: old settings still live (R8)
        cyc(4'h2, 4'h2, 1'b0, 4'd0, 8'h00, 1'b1, 3'd1, "R8 old config before wrap");
        for (int i = 0; i < 12; i++) begin
            cyc(VEC[i].act, VEC[i].rdy, 1'b0, 4'd0, 8'h00, VEC[i].v, VEC[i].tid,
                $sformatf("R2 vector %0d", i));
        end
        // Switch to round-robin mode mid-rotation; takes effect at next wrap
        cyc(4'hF, 4'hF, 1'b1, 4'd9, 8'h83, 1'b1, 3'd0, "R3 owner slot");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd2, "R8 mode deferred");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd1, "R8 table still live");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd3, "R6 srt pick");
        cyc(4'hF, 4'h2, 1'b0, 4'd0, 8'h00, 1'b1, 3'd1, "R9 rr mode live");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd2, "R9 rr order");
        cyc(4'h7, 4'hF, 1'b1, 4'd1, 8'h02, 1'b1, 3'd0, "R9 skip inactive");
        cyc(4'hF, 4'hF, 1'b1, 4'd9, 8'h01, 1'b1, 3'd1, "R9 rr last cycle");
        // Slot mode again, length 2, slot1 names SRT thread T2
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd0, "R7 new rotation slot0");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd2, "R10 srt-named entry");
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd0, "R7 length two wrap");
        cyc(4'hF, 4'hB, 1'b0, 4'd0, 8'h00, 1'b1, 3'd3, "R10 entry not reserved");
        // Reset again: defaults make every thread SRT, thread 0 first
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        #4 check("R11 defaults first pick", 1'b1, 3'd0);
        cyc(4'hF, 4'hF, 1'b0, 4'd0, 8'h00, 1'b1, 3'd1, "R11 defaults round robin");
        cyc(4'h0, 4'h0, 1'b0, 4'd0, 8'h00, 1'b0, 3'd0, "R1 none eligible");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule